// File: doc/BRIEF.md
# Tick-Based Memory Operation Sequencer

This block sits on the test side of a synchronous memory. It performs one memory access at a time: a read, a write, or a read-modify-write. Each access runs as a short, fixed list of ticks. A tick is one clock cycle, and it sets the memory's write enable, read enable and output enable. It also decides whether the write pattern is driven onto the data bus and whether the memory's output is captured. Any control that a tick leaves unnamed takes its idle level: the enables are off and the data bus is released. The tables describe only the level of each control in each cycle. Edge placement inside the cycle is handled by logic outside this block.

Requests arrive on a valid/ready interface that carries an operation code, an address and a write pattern. The block raises `req_ready` only while it is idle. A request moves only on a cycle where `req_valid` and `req_ready` are both high. While an access is running, `req_ready` is low and any `req_valid` is ignored. The requester may hold its request until it is accepted, or it may withdraw it. The captured read data and the completion flag are plain single-cycle pulses and have no back-pressure.

Top module: `memop_sequencer`

## Requirements
- R1: After reset, `req_ready` is 1, and `mem_we`, `mem_re`, `mem_oe`, `mem_dq_oe`, `cap_strobe`, `done` and `rd_valid` are all 0.
- R2: A request is accepted on a cycle with `req_valid` and `req_ready` both high. Its first tick occupies the next cycle. `req_ready` stays low from that first tick until the cycle in which `done` is high.
- R3: Read (code 2'b00) lasts two ticks. In tick 1, read enable is on. In tick 2, read enable stays on and the capture strobe is high.
- R4: Write (code 2'b01) lasts two ticks. In tick 1, write enable is on. In tick 2, every control is at its idle level.
- R5: Read-modify-write (code 2'b10) lasts two ticks. In tick 1, read enable is on. In tick 2, read enable is off, write enable is on and the capture strobe is high, all in the same cycle. Write and read enable are never on together.
- R6: Code 2'b11 is a no-operation. It lasts one tick, and in that tick every control is at its idle level.
- R7: `mem_dq_oe` is high exactly on ticks with write enable on. On those ticks, `mem_dq_out` carries the write pattern accepted with the request. `mem_addr` holds the accepted address on every tick of the access.
- R8: A capture strobe registers `mem_din` at the end of its cycle. In the next cycle, `rd_valid` pulses for one cycle and `rd_data` shows the captured word. `rd_data` changes at no other time.
- R9: `done` pulses for exactly one cycle, in the cycle right after the last tick of each accepted access.
- R10: A `req_valid` that arrives while an access is running has no effect. No extra access is started, and the running access's ticks, address and pattern are unchanged.
- R11: `mem_oe` is on exactly on the ticks where read enable is on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, one tick per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_op | input | 2 | Operation code: 00 read, 01 write, 10 read-modify-write, 11 no-operation |
| req_addr | input | ADDR_W | Address for the access |
| req_wdata | input | DATA_W | Write pattern |
| mem_addr | output | ADDR_W | Address to the memory |
| mem_we | output | 1 | Memory write enable |
| mem_re | output | 1 | Memory read enable |
| mem_oe | output | 1 | Memory output enable |
| mem_dq_out | output | DATA_W | Value driven onto the data bus |
| mem_dq_oe | output | 1 | Data bus drive enable (0 means high impedance) |
| mem_din | input | DATA_W | Data returned by the memory |
| cap_strobe | output | 1 | Capture strobe for the memory output |
| rd_data | output | DATA_W | Last captured read word |
| rd_valid | output | 1 | One-cycle pulse: `rd_data` was just updated |
| done | output | 1 | One-cycle pulse after the last tick |

## Verification
The bench model predicts the memory-side pins cycle by cycle, so a wrong tick counter or a wrong latched operation code is caught in the same cycle it occurs. Such an error shows up as an enable on the wrong tick, a missing strobe, or an access that is one tick too long or too short. A lost busy state shows up at once as `req_ready` rising early, or as an overlapping access started by a request sent while busy. A corrupted capture path shows up one cycle after the strobe, in `rd_data` and `rd_valid`.

// File: rtl/memop_pkg.sv
package memop_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'b00,
    OP_WRITE = 2'b01,
    OP_RMW   = 2'b10,
    OP_NOP   = 2'b11
  } op_e;

  // longest operation, in ticks
  localparam int unsigned MAX_TICKS = 2;
  localparam int unsigned TICK_W    = (MAX_TICKS > 1) ? $clog2(MAX_TICKS) : 1;

  // control levels applied during one tick
  typedef struct packed {
    logic we;
    logic re;
    logic oe;
    logic strobe;
    logic last;
  } tick_ctl_t;

  localparam tick_ctl_t CTL_IDLE = '{we: 1'b0, re: 1'b0, oe: 1'b0, strobe: 1'b0, last: 1'b0};

endpackage

// File: rtl/memop_tick_table.sv
module memop_tick_table
  import memop_pkg::*;
#(
  parameter int unsigned TW = TICK_W
) (
  input  op_e         op,
  input  logic [TW-1:0] tick,
  output tick_ctl_t   ctl
);

  logic first;
  assign first = (tick == '0);

  always_comb begin
    ctl = CTL_IDLE;
    unique case (op)
      OP_READ: begin
        ctl.re = 1'b1;
        ctl.oe = 1'b1;
        if (!first) begin
          ctl.strobe = 1'b1;
          ctl.last   = 1'b1;
        end
      end
      OP_WRITE: begin
        if (first) begin
          ctl.we = 1'b1;
        end else begin
          ctl.last = 1'b1;
        end
      end
      OP_RMW: begin
        if (first) begin
          ctl.re = 1'b1;
          ctl.oe = 1'b1;
        end else begin
          ctl.we     = 1'b1;
          ctl.strobe = 1'b1;
          ctl.last   = 1'b1;
        end
      end
      default: begin
        ctl.last = 1'b1;
      end
    endcase
  end

endmodule

// File: rtl/memop_ctrl.sv
module memop_ctrl
  import memop_pkg::*;
#(
  parameter int unsigned AW = 12,
  parameter int unsigned DW = 16,
  parameter int unsigned TW = TICK_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          tick_last,
  output logic          req_ready,
  output logic          active,
  output op_e           op_q,
  output logic [TW-1:0] tick_q,
  output logic [AW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic          done
);

  typedef enum logic {ST_IDLE, ST_RUN} st_e;

  st_e  state;
  logic accept;

  assign req_ready = (state == ST_IDLE);
  assign active    = (state == ST_RUN);
  assign accept    = req_valid && req_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_NOP;
      tick_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (accept) begin
            state   <= ST_RUN;
            op_q    <= op_e'(req_op);
            tick_q  <= '0;
            addr_q  <= req_addr;
            wdata_q <= req_wdata;
          end
        end
        default: begin
          if (tick_last) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            tick_q <= tick_q + 1'b1;
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/memop_capture.sv
module memop_capture #(
  parameter int unsigned DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= strobe;
      if (strobe) begin
        rd_data <= din;
      end
    end
  end

endmodule

// File: rtl/memop_sequencer.sv
module memop_sequencer
  import memop_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic              mem_re,
  output logic              mem_oe,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_din,
  output logic              cap_strobe,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid,
  output logic              done
);

  localparam int unsigned TW = TICK_W;

  logic          active;
  op_e           op_q;
  logic [TW-1:0] tick_q;
  logic [DATA_W-1:0] wdata_q;
  tick_ctl_t     ctl;
  logic          last_now;

  assign last_now = active && ctl.last;

  memop_ctrl #(
    .AW(ADDR_W),
    .DW(DATA_W),
    .TW(TW)
  ) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .tick_last (last_now),
    .req_ready (req_ready),
    .active    (active),
    .op_q      (op_q),
    .tick_q    (tick_q),
    .addr_q    (mem_addr),
    .wdata_q   (wdata_q),
    .done      (done)
  );

  memop_tick_table #(
    .TW(TW)
  ) u_table (
    .op   (op_q),
    .tick (tick_q),
    .ctl  (ctl)
  );

  // idle levels whenever no tick is in progress
  assign mem_we     = active && ctl.we;
  assign mem_re     = active && ctl.re;
  assign mem_oe     = active && ctl.oe;
  assign cap_strobe = active && ctl.strobe;
  assign mem_dq_oe  = mem_we;
  assign mem_dq_out = wdata_q;

  memop_capture #(
    .DW(DATA_W)
  ) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobe   (cap_strobe),
    .din      (mem_din),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

endmodule

// File: rtl/memop_sequencer_chk.sv
module memop_sequencer_chk #(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_we,
  input logic              mem_re,
  input logic              mem_oe,
  input logic              mem_dq_oe,
  input logic              cap_strobe,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid,
  input logic              done
);

  a_r2_busy_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  a_r5_we_re_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we && mem_re));

  a_r7_drive_needs_we: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_we);

  a_r7_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
    (!req_ready && $past(!req_ready)) |-> $stable(mem_addr));

  a_r8_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    cap_strobe |=> rd_valid);

  a_r8_data_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_valid |-> $stable(rd_data));

  a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r9_done_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> req_ready);

  a_r11_oe_needs_re: assert property (@(posedge clk) disable iff (!rst_n)
    mem_oe |-> mem_re);

endmodule

bind memop_sequencer memop_sequencer_chk #(
  .ADDR_W(ADDR_W),
  .DATA_W(DATA_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .mem_addr   (mem_addr),
  .mem_we     (mem_we),
  .mem_re     (mem_re),
  .mem_oe     (mem_oe),
  .mem_dq_oe  (mem_dq_oe),
  .cap_strobe (cap_strobe),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid),
  .done       (done)
);

// File: tb/memop_sequencer_test.sv
module memop_sequencer_test;

  localparam int AW = 12;
  localparam int DW = 16;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'b11;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [AW-1:0] mem_addr;
  logic          mem_we, mem_re, mem_oe, mem_dq_oe, cap_strobe;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_din = '0;
  logic [DW-1:0] rd_data;
  logic          rd_valid, done;

  int total = 0;
  int bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  memop_sequencer #(.ADDR_W(AW), .DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re), .mem_oe(mem_oe),
    .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe), .mem_din(mem_din),
    .cap_strobe(cap_strobe), .rd_data(rd_data), .rd_valid(rd_valid), .done(done)
  );

  // reference model: tick codes bit0 we, bit1 re, bit2 strobe; -1 = idle
  int tick_q[$];
  int cur = -1;
  int cur_op = 0;
  int op_run = 0;
  logic          m_done = 1'b0;
  logic          m_rdv = 1'b0;
  logic [DW-1:0] m_rdata = '0;
  logic [AW-1:0] m_addr = '0;
  logic [DW-1:0] m_wdata = '0;
  int accepted = 0;
  int dones = 0;
  int busy_hits = 0;

  task automatic chk(input string tag, input string nm, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h t=%0t", tag, nm, act, exp, $time);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0: return "R3";
      1: return "R4";
      2: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic compare_cycle();
    logic e_we, e_re, e_st;
    string t;
    e_we = (cur >= 0) && cur[0];
    e_re = (cur >= 0) && cur[1];
    e_st = (cur >= 0) && cur[2];
    t = op_tag(cur_op);
    chk("R2", "req_ready", 32'(req_ready), 32'(cur < 0));
    chk(t, "mem_we", 32'(mem_we), 32'(e_we));
    chk(t, "mem_re", 32'(mem_re), 32'(e_re));
    chk(t, "cap_strobe", 32'(cap_strobe), 32'(e_st));
    chk("R11", "mem_oe", 32'(mem_oe), 32'(e_re));
    chk("R7", "mem_dq_oe", 32'(mem_dq_oe), 32'(e_we));
    if (e_we) chk("R7", "mem_dq_out", 32'(mem_dq_out), 32'(m_wdata));
    if (cur >= 0) chk("R7", "mem_addr", 32'(mem_addr), 32'(m_addr));
    chk("R9", "done", 32'(done), 32'(m_done));
    chk("R8", "rd_valid", 32'(rd_valid), 32'(m_rdv));
    chk("R8", "rd_data", 32'(rd_data), 32'(m_rdata));
  endtask

  // advance the model to the next cycle using the inputs now applied
  task automatic model_step();
    logic e_st;
    e_st = (cur >= 0) && cur[2];
    m_done = (cur >= 0) && (tick_q.size() == 0);
    if (m_done) dones++;
    m_rdv = e_st;
    if (e_st) m_rdata = mem_din;
    if (cur < 0 && req_valid) begin
      accepted++;
      cur_op = int'(req_op);
      m_addr = req_addr;
      m_wdata = req_wdata;
      case (req_op)
        2'b00: begin tick_q.push_back(2); tick_q.push_back(6); end
        2'b01: begin tick_q.push_back(1); tick_q.push_back(0); end
        2'b10: begin tick_q.push_back(2); tick_q.push_back(5); end
        default: tick_q.push_back(0);
      endcase
      cur = tick_q.pop_front();
    end else if (cur >= 0 && req_valid) begin
      busy_hits++;   // R10: request while busy must be ignored
      cur = (tick_q.size() > 0) ? tick_q.pop_front() : -1;
    end else begin
      cur = (tick_q.size() > 0) ? tick_q.pop_front() : -1;
    end
  endtask

  // one cycle: compare at negedge, apply inputs, step model
  task automatic cycle(input logic v, input logic [1:0] op,
                       input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    compare_cycle();
    req_valid = v;
    req_op = op;
    req_addr = a;
    req_wdata = d;
    mem_din = DW'($urandom);
    model_step();
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // reset; R1 checked during and right after reset
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "req_ready", 32'(req_ready), 32'd1);
    chk("R1", "controls", 32'({mem_we, mem_re, mem_oe, mem_dq_oe, cap_strobe}), 32'd0);
    chk("R1", "pulses", 32'({done, rd_valid}), 32'd0);

    // directed: each operation back to back, held valid (R3 R4 R5 R6)
    for (int k = 0; k < 4; k++) begin
      for (int h = 0; h < 4; h++) cycle(1'b1, 2'(k), AW'(12'h100 + k), DW'(16'hA500 + k));
    end
    // R5 then R3 with idle gaps
    cycle(1'b1, 2'b10, 12'h0FF, 16'h1234);
    for (int h = 0; h < 3; h++) cycle(1'b0, 2'b00, '0, '0);
    cycle(1'b1, 2'b00, 12'hFFF, 16'hFFFF);
    for (int h = 0; h < 3; h++) cycle(1'b0, 2'b00, '0, '0);

    // R10: a request held high with changing fields while busy
    cycle(1'b1, 2'b01, 12'h0AA, 16'h5555);
    cycle(1'b1, 2'b00, 12'h0BB, 16'h6666);
    cycle(1'b1, 2'b10, 12'h0CC, 16'h7777);
    for (int h = 0; h < 3; h++) cycle(1'b0, 2'b00, '0, '0);

    // random traffic
    for (int n = 0; n < 3000; n++) begin
      cycle(1'($urandom), 2'($urandom), AW'($urandom), DW'($urandom));
    end
    for (int h = 0; h < 4; h++) cycle(1'b0, 2'b11, '0, '0);

    chk("R10", "done count vs accepted", 32'(dones), 32'(accepted));
    total++;
    if (busy_hits == 0) begin
      bad++;
      $display("FAIL R10 busy requests actual=0 expected>0");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule